// File: doc/BRIEF.md
# Pointer Post-Modify Address Unit

This unit generates data-memory addresses for indirect accesses in a small DSP coprocessor. It keeps two pointer/index pairs: pair 0 and pair 3. When the access strobe fires, the unit drives the selected pointer out as the address in that same cycle. At the next clock edge it adds a signed index to that pointer. The sum wraps modulo 2^16 and never saturates.

A single mode bit selects the index width. With the bit clear, the step is the 4-bit normal index. With the bit set, the extension nibble becomes the upper half of an 8-bit step and the normal nibble the lower half. The same bit also redirects host reads and writes of the index registers: while it is set, those accesses reach the extension nibbles instead of the normal ones.

The host port reads combinationally and writes on the clock edge. The mode bit has three sources: a direct write, a set command and a clear command. The access strobe and the host port have no back-pressure. Every strobe is taken in the cycle it is presented.

Top module: `ptr_agu`

## Requirements
- R1: While `acc_valid` is high, `acc_addr` shows the current value of the pointer chosen by `acc_sel` (0 = pair 0, 1 = pair 3) in the same cycle.
- R2: With the mode bit clear, an access advances the selected pointer at the next edge by its normal index nibble, read as a 4-bit two's complement value (for example 0xF steps by -1).
- R3: With the mode bit set, the step is the 8-bit two's complement value {extension nibble, normal nibble}, with the extension nibble in bits 7:4.
- R4: Pointer arithmetic wraps modulo 2^16 (0xFFFE + 3 = 0x0001, 0x0000 - 1 = 0xFFFF).
- R5: Host register address 0 is pointer 0, 1 is pointer 3, 2 is index 0 and 3 is index 3. Index accesses use data bits 3:0 and read back zero-extended. While the mode bit is set they reach the extension nibble, otherwise the normal nibble, and the other nibble is left unchanged.
- R6: The mode bit changes only through `mode_we` (loads `mode_wbit`), `mode_set` or `mode_clr`. Priority is write, then set, then clear. The new value is visible one edge later on `xmode`.
- R7: After reset, both pointers and all four index nibbles are zero and the mode bit is clear.
- R8: A host write to a pointer in the same cycle as an access to that pointer wins: the pointer takes the written value.
- R9: A pointer that is neither accessed nor written keeps its value, including while the other pair is being accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data (combinational) |
| mode_we | input | 1 | Mode bit write strobe |
| mode_wbit | input | 1 | Value loaded by a mode write |
| mode_set | input | 1 | Set-bit command for the mode bit |
| mode_clr | input | 1 | Clear-bit command for the mode bit |
| acc_valid | input | 1 | Indirect access strobe |
| acc_sel | input | 1 | Pair select for the access |
| acc_addr | output | 16 | Address of the access (selected pointer) |
| xmode | output | 1 | Current mode bit (1 = 8-bit index, extension bank) |

## Verification
The access address and host read data are combinational, so they are due in the cycle of the stimulus. The bench samples them shortly after driving its inputs at the falling edge. A pointer update, an index or pointer write, and a mode change all land on the next rising edge. The bench therefore checks them at the following falling edge, through `reg_rdata` or `xmode`, before issuing any further stimulus. Mixed-sign steps, wrap-around, the write-versus-access collision and the mode-command priority each get their own directed scenario with precomputed expected values.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  localparam int PTR_W_DEF = 16;
  localparam int NIB_W_DEF = 4;
  localparam int NUM_PAIRS = 2;

  // host register map; bit 1 separates pointers from indices, bit 0 picks the pair
  typedef enum logic [1:0] {
    RA_PTR0 = 2'd0,
    RA_PTR3 = 2'd1,
    RA_IDX0 = 2'd2,
    RA_IDX3 = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/agu_mode_reg.sv
module agu_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wbit,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (we)      mode_q <= wbit;
    else if (set_cmd) mode_q <= 1'b1;
    else if (clr_cmd) mode_q <= 1'b0;
  end
endmodule

// File: rtl/agu_index_bank.sv
module agu_index_bank #(
  parameter int NIB_W = ptr_agu_pkg::NIB_W_DEF
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     mode_x,
  input  logic                                     we,
  input  logic [1:0]                               addr,
  input  logic [NIB_W-1:0]                         wdata,
  output logic [NIB_W-1:0]                         rdata,
  output logic [ptr_agu_pkg::NUM_PAIRS-1:0][NIB_W-1:0] nrm_q,
  output logic [ptr_agu_pkg::NUM_PAIRS-1:0][NIB_W-1:0] ext_q
);
  localparam int NP = ptr_agu_pkg::NUM_PAIRS;

  for (genvar g = 0; g < NP; g++) begin : g_pair
    logic             hit;
    logic [NIB_W-1:0] n_r, e_r;
    assign hit = we && addr[1] && (addr[0] == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        n_r <= '0;
        e_r <= '0;
      end else if (hit) begin
        if (mode_x) e_r <= wdata;
        else        n_r <= wdata;
      end
    end
    assign nrm_q[g] = n_r;
    assign ext_q[g] = e_r;
  end

  always_comb begin
    rdata = mode_x ? ext_q[addr[0]] : nrm_q[addr[0]];
  end
endmodule

// File: rtl/agu_step_gen.sv
module agu_step_gen #(
  parameter int PTR_W = ptr_agu_pkg::PTR_W_DEF,
  parameter int NIB_W = ptr_agu_pkg::NIB_W_DEF
) (
  input  logic             mode_x,
  input  logic [NIB_W-1:0] nrm,
  input  logic [NIB_W-1:0] ext,
  output logic [PTR_W-1:0] step
);
  localparam int WIDE_W = 2 * NIB_W;

  logic [WIDE_W-1:0] wide_idx;
  assign wide_idx = {ext, nrm};

  always_comb begin
    if (mode_x) step = {{(PTR_W-WIDE_W){wide_idx[WIDE_W-1]}}, wide_idx};
    else        step = {{(PTR_W-NIB_W){nrm[NIB_W-1]}}, nrm};
  end
endmodule

// File: rtl/agu_pointer_file.sv
module agu_pointer_file #(
  parameter int PTR_W = ptr_agu_pkg::PTR_W_DEF
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         we,
  input  logic [1:0]                                   addr,
  input  logic [PTR_W-1:0]                             wdata,
  input  logic                                         acc_valid,
  input  logic                                         acc_sel,
  input  logic [PTR_W-1:0]                             step,
  output logic [ptr_agu_pkg::NUM_PAIRS-1:0][PTR_W-1:0] ptr_q
);
  localparam int NP = ptr_agu_pkg::NUM_PAIRS;

  for (genvar g = 0; g < NP; g++) begin : g_ptr
    logic             hit, adv;
    logic [PTR_W-1:0] p_r;
    assign hit = we && !addr[1] && (addr[0] == 1'(g));
    assign adv = acc_valid && (acc_sel == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   p_r <= '0;
      else if (hit) p_r <= wdata;
      else if (adv) p_r <= p_r + step;
    end
    assign ptr_q[g] = p_r;
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int PTR_W = ptr_agu_pkg::PTR_W_DEF,
  parameter int NIB_W = ptr_agu_pkg::NIB_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [PTR_W-1:0] reg_wdata,
  output logic [PTR_W-1:0] reg_rdata,
  input  logic             mode_we,
  input  logic             mode_wbit,
  input  logic             mode_set,
  input  logic             mode_clr,
  input  logic             acc_valid,
  input  logic             acc_sel,
  output logic [PTR_W-1:0] acc_addr,
  output logic             xmode
);
  localparam int NP = ptr_agu_pkg::NUM_PAIRS;

  logic                        mode_q;
  logic [NIB_W-1:0]            idx_rd;
  logic [NP-1:0][NIB_W-1:0]    nrm_q, ext_q;
  logic [NP-1:0][PTR_W-1:0]    ptr_q;
  logic [PTR_W-1:0]            step;

  agu_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wbit(mode_wbit),
    .set_cmd(mode_set), .clr_cmd(mode_clr), .mode_q(mode_q)
  );

  agu_index_bank #(.NIB_W(NIB_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .mode_x(mode_q), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata[NIB_W-1:0]), .rdata(idx_rd), .nrm_q(nrm_q), .ext_q(ext_q)
  );

  agu_step_gen #(.PTR_W(PTR_W), .NIB_W(NIB_W)) u_step (
    .mode_x(mode_q), .nrm(nrm_q[acc_sel]), .ext(ext_q[acc_sel]), .step(step)
  );

  agu_pointer_file #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .acc_valid(acc_valid), .acc_sel(acc_sel), .step(step), .ptr_q(ptr_q)
  );

  assign acc_addr = ptr_q[acc_sel];
  assign xmode    = mode_q;

  always_comb begin
    if (reg_addr[1]) reg_rdata = {{(PTR_W-NIB_W){1'b0}}, idx_rd};
    else             reg_rdata = ptr_q[reg_addr[0]];
  end
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int PTR_W = 16,
  parameter int NIB_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [1:0]            reg_addr,
  input logic [PTR_W-1:0]      reg_wdata,
  input logic                  mode_we,
  input logic                  mode_wbit,
  input logic                  mode_set,
  input logic                  mode_clr,
  input logic                  acc_valid,
  input logic                  acc_sel,
  input logic [PTR_W-1:0]      acc_addr,
  input logic                  xmode,
  input logic [1:0][PTR_W-1:0] ptr_q
);
  localparam int SHORT_MIN = -(1 << (NIB_W - 1));
  localparam int SHORT_MAX = (1 << (NIB_W - 1)) - 1;

  assert_host_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr[1]) |=> ptr_q[$past(reg_addr[0])] == $past(reg_wdata));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !(reg_we && reg_addr == 2'd0)) |=> $stable(ptr_q[0]));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_we && !mode_set && !mode_clr) |=> $stable(xmode));

  assert_mode_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (xmode == $past(mode_wbit)));

  assert_short_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !xmode && !(reg_we && !reg_addr[1] && reg_addr[0] == acc_sel))
    |=> ($signed(PTR_W'(ptr_q[$past(acc_sel)] - $past(acc_addr))) >= SHORT_MIN &&
         $signed(PTR_W'(ptr_q[$past(acc_sel)] - $past(acc_addr))) <= SHORT_MAX));
endmodule

bind ptr_agu ptr_agu_chk #(.PTR_W(PTR_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/ptr_agu_test.sv
module ptr_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mode_we = 1'b0, mode_wbit = 1'b0, mode_set = 1'b0, mode_clr = 1'b0;
  logic        acc_valid = 1'b0, acc_sel = 1'b0;
  logic [15:0] acc_addr;
  logic        xmode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ptr_agu uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_we(mode_we),
    .mode_wbit(mode_wbit), .mode_set(mode_set), .mode_clr(mode_clr),
    .acc_valid(acc_valid), .acc_sel(acc_sel), .acc_addr(acc_addr), .xmode(xmode)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic access(input logic s, output logic [15:0] seen);
    @(negedge clk);
    acc_valid = 1'b1; acc_sel = s;
    #1 seen = acc_addr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic mode_cmd(input logic w, input logic b, input logic s, input logic c);
    @(negedge clk);
    mode_we = w; mode_wbit = b; mode_set = s; mode_clr = c;
    @(negedge clk);
    mode_we = 1'b0; mode_set = 1'b0; mode_clr = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R7 reset register", v, 16'h0000);
    end
    chk("R7 reset mode", {15'd0, xmode}, 16'h0000);
    acc_sel = 1'b0;
    #1 chk("R7 reset address", acc_addr, 16'h0000);
  endtask

  task automatic t_short;
    logic [15:0] v;
    wr(2'd0, 16'h1000); wr(2'd2, 16'h0003);
    wr(2'd1, 16'h2000); wr(2'd3, 16'hFFFF);
    rd(2'd0, v); chk("R5 read ptr0", v, 16'h1000);
    rd(2'd3, v); chk("R5 index zero-extended", v, 16'h000F);
    access(1'b0, v); chk("R1 address ptr0", v, 16'h1000);
    rd(2'd0, v); chk("R2 step +3", v, 16'h1003);
    rd(2'd1, v); chk("R9 other pair held", v, 16'h2000);
    access(1'b1, v); chk("R1 address ptr3", v, 16'h2000);
    rd(2'd1, v); chk("R2 step -1", v, 16'h1FFF);
    repeat (2) @(negedge clk);
    rd(2'd0, v); chk("R9 idle hold", v, 16'h1003);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    wr(2'd0, 16'hFFFE);
    access(1'b0, v);
    rd(2'd0, v); chk("R4 wrap up", v, 16'h0001);
    wr(2'd1, 16'h0001);
    access(1'b1, v);
    access(1'b1, v);
    rd(2'd1, v); chk("R4 wrap down", v, 16'hFFFF);
  endtask

  task automatic t_mode;
    logic [15:0] v;
    mode_cmd(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 set command", {15'd0, xmode}, 16'h0001);
    wr(2'd2, 16'h0008);
    rd(2'd2, v); chk("R5 extension bank write", v, 16'h0008);
    mode_cmd(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 clear command", {15'd0, xmode}, 16'h0000);
    rd(2'd2, v); chk("R5 normal nibble untouched", v, 16'h0003);
    mode_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 write beats set", {15'd0, xmode}, 16'h0000);
    mode_cmd(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 set beats clear", {15'd0, xmode}, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R6 mode held", {15'd0, xmode}, 16'h0001);
  endtask

  task automatic t_long;
    logic [15:0] v;
    wr(2'd0, 16'h1000);
    access(1'b0, v);
    rd(2'd0, v); chk("R3 step 0x83 = -125", v, 16'h0F83);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h2000);
    access(1'b1, v);
    rd(2'd1, v); chk("R3 step 0x0F = +15", v, 16'h200F);
    mode_cmd(1'b0, 1'b0, 1'b0, 1'b1);
    rd(2'd3, v); chk("R5 normal index3 read", v, 16'h000F);
    access(1'b1, v);
    rd(2'd1, v); chk("R3 back to short step", v, 16'h200E);
  endtask

  task automatic t_prio;
    logic [15:0] v;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h5555;
    acc_valid = 1'b1; acc_sel = 1'b0;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    rd(2'd0, v); chk("R8 host write wins", v, 16'h5555);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h1234;
    acc_valid = 1'b1; acc_sel = 1'b0;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    rd(2'd0, v); chk("R9 access beside write", v, 16'h5558);
    rd(2'd1, v); chk("R8 write other pointer", v, 16'h1234);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_short();
    t_wrap();
    t_mode();
    t_long();
    t_prio();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule